// File: doc/BRIEF.md
# Holdover History Manager

This block keeps the frequency history that a timing loop falls back on when it loses its reference. Frequency words arrive on a sample stream while the loop is locked and feed a simple averaging accumulator. After a programmable build time the accumulated value is promoted into an active history word. From then on the active word follows the accumulator. A third, backup word can be written from the active history or copied back into it under command, and a flush discards the active history and the accumulator.

A policy input chooses what happens when the loop moves to a different reference. The history can be rebuilt from scratch, or accumulation can simply continue. While the loop is in Hold Over, the output frequency word comes from the active history. If no history exists, the previous word is held. A saturating counter reports the whole hours spent in Hold Over. The build time and the hour length are parameters counted in system clock cycles.

The sample stream uses valid/ready. The sink never applies back-pressure: `smp_ready` is held high. A beat is accepted on every cycle with `smp_valid` high, and it is used only when `locked` is high. Beats offered while unlocked are dropped. Every other pin is a plain level or a single-cycle strobe.

Top module: `holdover_hist_mgr`

## Requirements
- R1: When `cmd_valid` is high, the 2-bit `cmd` field is latched into `cmd_last` on the next edge. The field encoding is 00 = no action, 01 = save, 10 = restore, 11 = flush. `cmd_last` resets to 00, and a 00 command changes no history state.
- R2: Save (01) copies the active history into the backup word and records whether that history was available. When a save coincides with an active-history update, the backup receives the active value from before that edge.
- R3: Flush (11) sets the active history and the accumulator to 0, clears `hist_avail` and `build_done`, and restarts the build timer. The backup word is left unchanged.
- R4: Restore (10) loads the backup word into both the active history and the accumulator, and sets `hist_avail` to the backup's recorded availability. It clears `build_done` and restarts the build timer.
- R5: A sample is used when `smp_valid` and `locked` are both high, and no flush or restore is applied in that cycle. The first used sample after reset, a flush or a rebuild loads the accumulator directly. Later samples update it as acc + ((sample - acc) >>> AVG_SHIFT), with a signed difference and an arithmetic shift.
- R6: The build timer counts only on cycles with `locked` high. On its BUILD_CYCLES-th counted cycle, the active history takes the accumulator value and `hist_avail` and `build_done` go to 1. While `build_done` is 1, the active history takes the accumulator value on every edge, which is a one-cycle lag.
- R7: When `ref_switch` pulses with `keep_on_switch` at 0, `build_done` clears, the timer restarts and the accumulator is re-primed. A sample offered in that same cycle becomes the new first sample. Active history and `hist_avail` are kept. With `keep_on_switch` at 1, a switch has no effect.
- R8: Flush takes priority over build completion in the same cycle. Restore takes priority over a reference-switch rebuild and over a sample in the same cycle.
- R9: `ho_hours` is 0 whenever `holdover` is low. While `holdover` is high, it increases by one every HOUR_CYCLES cycles and stops at 255.
- R10: A used-or-offered sample taken while locked sets `freq_word` on the next edge. Otherwise, with `holdover` high and `hist_avail` at 1, `freq_word` takes the active history. Otherwise `freq_word` holds, including in Hold Over with no history available.
- R11: `smp_ready` is always 1. A beat offered while `locked` is low changes neither `freq_word` nor the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Frequency sample valid |
| smp_ready | output | 1 | Sample sink ready (always 1) |
| smp_data | input | W | Frequency sample word |
| locked | input | 1 | Loop is locked to a reference |
| holdover | input | 1 | Loop is in Hold Over |
| ref_switch | input | 1 | One-cycle strobe: the reference changed |
| keep_on_switch | input | 1 | Policy: 1 continue, 0 rebuild on a switch |
| cmd_valid | input | 1 | Command write strobe |
| cmd | input | 2 | Command code |
| cmd_last | output | 2 | Last written command |
| active_hist | output | W | Active history word |
| backup_hist | output | W | Backup history word |
| hist_avail | output | 1 | Active history is usable |
| build_done | output | 1 | Build finished, active follows accumulator |
| freq_word | output | W | Output frequency word |
| ho_hours | output | 8 | Hours spent in Hold Over, saturating |

## Verification
Two collisions need care. In the first, a flush is written in exactly the cycle in which the build timer would promote the accumulator. The bench provokes this by counting locked cycles after a rebuild and issuing the flush on the last one. It then expects the active history to be 0 with both flags low, not the promoted value. In the second, a restore arrives together with a rebuild-policy reference switch and a fresh sample. After the next build completes, the active history must still equal the backup word, which shows that the sample never entered the accumulator.

// File: rtl/hh_pkg.sv
package hh_pkg;
  typedef enum logic [1:0] {
    HH_NOP     = 2'b00,
    HH_SAVE    = 2'b01,
    HH_RESTORE = 2'b10,
    HH_FLUSH   = 2'b11
  } hh_cmd_e;

  localparam int HH_HOURS_W = 8;
endpackage

// File: rtl/hh_accum.sv
module hh_accum #(
  parameter int W        = 16,
  parameter int AVG_SHIFT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         seed,
  input  logic [W-1:0] seed_val,
  input  logic         seed_primed,
  input  logic         restart,
  input  logic         take,
  input  logic [W-1:0] sample,
  output logic [W-1:0] acc
);
  logic          primed;
  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic [W-1:0]  avg;

  always_comb begin
    diff = $signed({1'b0, sample}) - $signed({1'b0, acc});
    step = diff >>> AVG_SHIFT;
    avg  = acc + step[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc    <= '0;
      primed <= 1'b0;
    end else if (seed) begin
      acc    <= seed_val;
      primed <= seed_primed;
    end else if (take) begin
      acc    <= (primed && !restart) ? avg : sample;
      primed <= 1'b1;
    end else if (restart) begin
      primed <= 1'b0;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0); // R3
  AST_FIRST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear && !seed && (restart || !primed)) |=> acc == $past(sample)); // R5
endmodule

// File: rtl/hh_build.sv
module hh_build #(
  parameter longint unsigned BUILD_CYCLES = 64'd180000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic fire,
  output logic done
);
  localparam int BW = $clog2(BUILD_CYCLES + 1);
  localparam logic [BW-1:0] LAST = BW'(BUILD_CYCLES - 1);

  logic [BW-1:0] cnt;

  assign fire = run && !done && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (fire) begin
      done <= 1'b1;
    end else if (run && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> done); // R6
  AST_PAUSE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt)); // R6
endmodule

// File: rtl/hh_elapsed.sv
module hh_elapsed #(
  parameter longint unsigned HOUR_CYCLES = 64'd720000000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       holdover,
  output logic [hh_pkg::HH_HOURS_W-1:0] hours
);
  localparam int TW = $clog2(HOUR_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(HOUR_CYCLES - 1);
  localparam logic [hh_pkg::HH_HOURS_W-1:0] HMAX = '1;

  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n || !holdover) begin
      tick  <= '0;
      hours <= '0;
    end else if (tick == TLAST) begin
      tick <= '0;
      if (hours != HMAX) hours <= hours + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  AST_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover |=> hours == '0); // R9
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && hours == HMAX) |=> hours == HMAX); // R9
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |=> (hours == $past(hours) || hours == $past(hours) + 1'b1)); // R9
endmodule

// File: rtl/holdover_hist_mgr.sv
module holdover_hist_mgr #(
  parameter int              W            = 16,
  parameter int              AVG_SHIFT    = 2,
  parameter longint unsigned BUILD_CYCLES = 64'd180000000,
  parameter longint unsigned HOUR_CYCLES  = 64'd720000000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  input  logic         locked,
  input  logic         holdover,
  input  logic         ref_switch,
  input  logic         keep_on_switch,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd,
  output logic [1:0]   cmd_last,
  output logic [W-1:0] active_hist,
  output logic [W-1:0] backup_hist,
  output logic         hist_avail,
  output logic         build_done,
  output logic [W-1:0] freq_word,
  output logic [7:0]   ho_hours
);
  import hh_pkg::*;

  logic         do_save, do_restore, do_flush, rebuild, take, fire, bkp_avail;
  logic [W-1:0] acc;

  assign smp_ready  = 1'b1;
  assign do_save    = cmd_valid && (cmd == HH_SAVE);
  assign do_restore = cmd_valid && (cmd == HH_RESTORE);
  assign do_flush   = cmd_valid && (cmd == HH_FLUSH);
  assign rebuild    = ref_switch && !keep_on_switch && !do_flush && !do_restore;
  assign take       = smp_valid && locked && !do_flush && !do_restore;

  hh_accum #(.W(W), .AVG_SHIFT(AVG_SHIFT)) i_accum (
    .clk(clk), .rst_n(rst_n), .clear(do_flush), .seed(do_restore),
    .seed_val(backup_hist), .seed_primed(bkp_avail), .restart(rebuild),
    .take(take), .sample(smp_data), .acc(acc)
  );

  hh_build #(.BUILD_CYCLES(BUILD_CYCLES)) i_build (
    .clk(clk), .rst_n(rst_n), .clear(do_flush || do_restore || rebuild),
    .run(locked), .fire(fire), .done(build_done)
  );

  hh_elapsed #(.HOUR_CYCLES(HOUR_CYCLES)) i_elapsed (
    .clk(clk), .rst_n(rst_n), .holdover(holdover), .hours(ho_hours)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_hist <= '0;
      hist_avail  <= 1'b0;
    end else if (do_flush) begin
      active_hist <= '0;
      hist_avail  <= 1'b0;
    end else if (do_restore) begin
      active_hist <= backup_hist;
      hist_avail  <= bkp_avail;
    end else if (fire) begin
      active_hist <= acc;
      hist_avail  <= 1'b1;
    end else if (build_done && !rebuild) begin
      active_hist <= acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      backup_hist <= '0;
      bkp_avail   <= 1'b0;
    end else if (do_save) begin
      backup_hist <= active_hist;
      bkp_avail   <= hist_avail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cmd_last <= HH_NOP;
    else if (cmd_valid) cmd_last <= cmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        freq_word <= '0;
    else if (smp_valid && locked)      freq_word <= smp_data;
    else if (holdover && hist_avail)   freq_word <= active_hist;
  end

  AST_CMD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_last == $past(cmd)); // R1
  AST_SAVE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    do_save |=> backup_hist == $past(active_hist)); // R2
  AST_FLUSH_KEEPS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush |=> (backup_hist == $past(backup_hist) && !hist_avail && !build_done
                  && active_hist == '0)); // R3
  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> (active_hist == $past(backup_hist) && !build_done)); // R4
  AST_DONE_IMPLIES_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    build_done |-> hist_avail); // R6
  AST_HOLD_NO_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !hist_avail && !(smp_valid && locked)) |=> $stable(freq_word)); // R10
endmodule

// File: tb/test_holdover_hist_mgr.sv
`timescale 1ns/1ps
module test_holdover_hist_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_ready;
  logic [15:0] smp_data = '0;
  logic        locked = 1'b0, holdover = 1'b0, ref_switch = 1'b0, keep_on_switch = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = 2'b00, cmd_last;
  logic [15:0] active_hist, backup_hist, freq_word;
  logic        hist_avail, build_done;
  logic [7:0]  ho_hours;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  holdover_hist_mgr #(.W(16), .AVG_SHIFT(1), .BUILD_CYCLES(64'd4), .HOUR_CYCLES(64'd3)) i_holdover_hist_mgr (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .locked(locked), .holdover(holdover), .ref_switch(ref_switch),
    .keep_on_switch(keep_on_switch), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_last(cmd_last),
    .active_hist(active_hist), .backup_hist(backup_hist), .hist_avail(hist_avail),
    .build_done(build_done), .freq_word(freq_word), .ho_hours(ho_hours)
  );

  // sample, expected freq_word, expected active_hist, expected hist_avail
  localparam int TBL [6][4] = '{
    '{100, 100,   0, 0}, '{200, 200,   0, 0}, '{300, 300,   0, 0},
    '{300, 300, 225, 1}, '{500, 500, 262, 1}, '{100, 100, 381, 1}};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    smp_valid = 0; cmd_valid = 0; ref_switch = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // reset state
    chk("R1 reset cmd_last", cmd_last, 0);
    chk("R6 reset avail", hist_avail, 0);
    chk("R6 reset build_done", build_done, 0);
    chk("R10 reset freq", freq_word, 0);
    chk("R9 reset hours", ho_hours, 0);
    chk("R11 ready", smp_ready, 1);

    // table walk: R5 averaging and R6 promotion
    locked = 1;
    for (int i = 0; i < 6; i++) begin
      smp_valid = 1; smp_data = 16'(TBL[i][0]);
      step();
      chk("R10 freq follows sample", freq_word, TBL[i][1]);
      chk("R5 R6 active", active_hist, TBL[i][2]);
      chk("R6 avail", hist_avail, TBL[i][3]);
      chk("R6 build_done", build_done, TBL[i][3]);
    end
    idle(); step();
    chk("R6 active tracks acc", active_hist, 240);
    chk("R10 freq held", freq_word, 100);

    // null command: no effect
    cmd_valid = 1; cmd = 2'b00; step(); idle();
    chk("R1 nop latched", cmd_last, 0);
    chk("R1 nop backup", backup_hist, 0);

    // save
    cmd_valid = 1; cmd = 2'b01; step(); idle();
    chk("R1 save latched", cmd_last, 1);
    chk("R2 save", backup_hist, 240);

    // save colliding with sync update and a new sample
    cmd_valid = 1; cmd = 2'b01; smp_valid = 1; smp_data = 1000; step(); idle();
    chk("R2 save takes pre-edge active", backup_hist, 240);
    step();
    chk("R5 avg with 1000", active_hist, 620);

    // flush with a sample in the same cycle
    cmd_valid = 1; cmd = 2'b11; smp_valid = 1; smp_data = 700; step(); idle();
    chk("R3 flush active", active_hist, 0);
    chk("R3 flush avail", hist_avail, 0);
    chk("R3 flush build_done", build_done, 0);
    chk("R3 flush keeps backup", backup_hist, 240);
    chk("R1 flush latched", cmd_last, 3);
    chk("R10 freq on flush cycle", freq_word, 700);
    smp_valid = 1; smp_data = 50; step(); idle();
    step(); step();
    chk("R6 not yet promoted", hist_avail, 0);
    step();
    chk("R3 R5 acc restarted", active_hist, 50);
    chk("R6 promoted", build_done, 1);

    // restore
    cmd_valid = 1; cmd = 2'b10; step(); idle();
    chk("R4 restore active", active_hist, 240);
    chk("R4 restore avail", hist_avail, 1);
    chk("R4 restore build_done", build_done, 0);
    chk("R1 restore latched", cmd_last, 2);
    step(); step(); step();
    chk("R4 rebuild pending", build_done, 0);
    step();
    chk("R4 rebuild done", build_done, 1);
    chk("R4 seeded acc", active_hist, 240);

    // continue policy
    keep_on_switch = 1; ref_switch = 1; step(); idle();
    chk("R7 continue keeps build_done", build_done, 1);

    // rebuild policy with a sample in the same cycle
    keep_on_switch = 0; ref_switch = 1; smp_valid = 1; smp_data = 400; step(); idle();
    chk("R7 rebuild clears build_done", build_done, 0);
    chk("R7 rebuild keeps active", active_hist, 240);
    chk("R7 rebuild keeps avail", hist_avail, 1);
    step(); step(); step();
    chk("R7 active frozen", active_hist, 240);
    step();
    chk("R7 new history", active_hist, 400);

    // flush on the promotion cycle
    ref_switch = 1; step(); idle();
    step(); step(); step();
    cmd_valid = 1; cmd = 2'b11; step(); idle();
    chk("R8 flush beats promotion active", active_hist, 0);
    chk("R8 flush beats promotion avail", hist_avail, 0);
    chk("R8 flush beats promotion done", build_done, 0);

    // restore together with a rebuild switch and a sample
    cmd_valid = 1; cmd = 2'b10; ref_switch = 1; smp_valid = 1; smp_data = 900; step(); idle();
    chk("R8 restore wins active", active_hist, 240);
    step(); step(); step(); step();
    chk("R8 sample discarded", active_hist, 240);
    chk("R8 build after restore", build_done, 1);

    // holdover with history
    locked = 0; holdover = 1; step();
    chk("R10 holdover uses history", freq_word, 240);
    chk("R9 hours start", ho_hours, 0);
    smp_valid = 1; smp_data = 777; step(); idle();
    chk("R11 unlocked beat dropped", freq_word, 240);
    chk("R11 unlocked beat not used", active_hist, 240);
    step();
    chk("R9 one hour", ho_hours, 1);
    repeat (800) step();
    chk("R9 saturates", ho_hours, 255);
    holdover = 0; step();
    chk("R9 zero outside holdover", ho_hours, 0);

    // holdover without history holds the word
    cmd_valid = 1; cmd = 2'b11; step(); idle();
    holdover = 1; step(); step(); step();
    chk("R10 no history holds word", freq_word, 240);
    chk("R3 flushed history", active_hist, 0);
    holdover = 0;
    finish_run();
  end
endmodule